// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair

This block joins two eight-input priority interrupt controller slices into one sixteen-line unit for a processor. The first slice (the master) drives the processor interrupt line. The second slice (the slave) reports into the master through master input 2. The block claims six byte-wide I/O addresses: a command port and a data port for each slice, and a trigger-mode register for each slice. All other addresses and all accesses wider or narrower than one byte leave the block untouched.

Each slice latches requests on a rising edge, or follows the line level where its trigger-mode bit says so. Requests can be masked. The slice picks a winner by rotating priority and holds serviced lines in an in-service register until an end-of-interrupt command clears them, or clears them itself in auto-EOI mode. A one-cycle acknowledge pulse asks the pair for a vector. The master's winner is acknowledged first. If that winner is input 2, the slave's winner is acknowledged as well. A side with nothing eligible answers with its own line 7.

Top module: `pic_pair`

## Requirements
- R1: Byte address 0x20 is the master command port and 0x21 its data port; 0xA0 and 0xA1 are the same pair for the slave. A read of the data port returns the mask register. A read of the command port returns the request register after reset. Command byte 0x0B switches it to the in-service register and 0x0A switches it back.
- R2: A read of any other address returns 0x00. A write to any other address changes no register.
- R3: Only accesses with size input equal to 1 have an effect. Any other size is ignored on write and reads back 0x00.
- R4: Request line n belongs to slice n>>3, input n&7. In edge mode a rising edge latches the request and the vector is the slice base plus the input number.
- R5: Address 0x4D0 is the master trigger-mode register and 0x4D1 the slave's; bit i set makes input i level-sensitive. Only bits 0xF8 (master) and 0xDE (slave) are writable. A level request follows the line and is not cleared by acknowledge.
- R6: While the slave has an eligible request, master input 2 receives a request. The processor interrupt line is high exactly when the master has an eligible request.
- R7: When an acknowledge finds a master winner other than input 2, the vector is master base plus that input. The input's in-service bit is set and its edge request is cleared.
- R8: When the master winner is input 2, the slave is acknowledged too and the vector is slave base plus the slave winner. If the slave has nothing eligible, the vector is slave base plus 7.
- R9: When the master has nothing eligible at acknowledge, the vector is master base plus 7.
- R10: Lower input number has higher priority. An in-service input blocks itself and all lower priority inputs. Command 0x20 clears the highest priority in-service bit.
- R11: A masked input stays pending but is never delivered until unmasked.
- R12: A command byte with bit 4 set starts initialization and clears the mask. The next data byte sets the base, with its low three bits dropped. The byte after that is consumed. If bit 0 of the first byte was set, a fourth byte follows, and bit 1 of that byte enables auto-EOI: acknowledged inputs are not left in service.
- R13: Command 0xC0|n makes input n the lowest priority, so input n+1 (mod 8) becomes the highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 16 | Interrupt request lines |
| ioAddr | input | 16 | I/O byte address |
| ioWrData | input | 8 | Write data |
| ioWrEn | input | 1 | Write strobe |
| ioRdEn | input | 1 | Read strobe |
| ioSize | input | 3 | Access size in bytes |
| intAck | input | 1 | Interrupt acknowledge pulse |
| cpuInt | output | 1 | Processor interrupt request |
| ioRdData | output | 8 | Read data, valid the cycle after the read strobe |
| intVector | output | 8 | Vector, valid the cycle after the acknowledge |

## Verification
The main sweep raises each of the sixteen lines on its own, acknowledges it and closes it with end-of-interrupt. This separates master lines from slave lines, a slave line from the external input 2, and the base of one slice from the other, and it checks that the interrupt line drops afterwards. Paired requests (3 and 5, then 1 and 6 after a priority rotation) separate fixed from rotated priority and show in-service blocking. A masked line and the external input 2 give the two spurious vectors. A level-mode line, read back through the request register while it rises and falls, separates level from edge latching.

// File: rtl/pic_pair_pkg.sv
package pic_pair_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int BYTE_W = 8;
  localparam int BASE_W = BYTE_W - IDX_W;
  localparam int SLICES = 2;

  typedef struct packed {
    logic             cmdWr;
    logic             dataWr;
    logic             trigWr;
    logic             ackEn;
    logic [IDX_W-1:0] ackIdx;
  } sliceStrobe_t;

  typedef struct packed {
    logic              winValid;
    logic [IDX_W-1:0]  winIdx;
    logic [BASE_W-1:0] base;
    logic [LINES-1:0]  regView;
    logic [LINES-1:0]  imr;
    logic [LINES-1:0]  elcr;
    logic [LINES-1:0]  irr;
  } sliceView_t;

  typedef enum logic [1:0] {STEP_IDLE, STEP_BASE, STEP_CASC, STEP_MODE} initStep_t;

  typedef enum logic [2:0] {HIT_NONE, HIT_MCMD, HIT_MDATA, HIT_SCMD,
                            HIT_SDATA, HIT_MTRIG, HIT_STRIG} portHit_t;

  // Rotated priority of the best set bit; LINES when none is set.
  function automatic logic [IDX_W:0] pickPrio(logic [LINES-1:0] m, logic [IDX_W-1:0] add);
    logic [IDX_W:0] p;
    p = (IDX_W+1)'(LINES);
    for (int i = LINES - 1; i >= 0; i--) begin
      if (m[IDX_W'(IDX_W'(i) + add)]) p = (IDX_W+1)'(i);
    end
    return p;
  endfunction
endpackage

// File: rtl/pic_slice.sv
module pic_slice
  import pic_pair_pkg::*;
#(
  parameter bit               IS_MASTER    = 1'b0,
  parameter logic [LINES-1:0] TRIG_MASK    = '0,
  parameter int               CASCADE_LINE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  reqLines,
  input  logic [LINES-1:0]  injLines,
  input  sliceStrobe_t      strobe,
  input  logic [BYTE_W-1:0] wrData,
  output sliceView_t        view,
  output logic              intOut
);
  logic [LINES-1:0]  irr, imr, isr, elcr, lastReq;
  logic [LINES-1:0]  irrN, imrN, isrN, elcrN;
  logic [IDX_W-1:0]  prioAdd, prioAddN;
  logic [BASE_W-1:0] base, baseN;
  logic              readIsr, readIsrN, autoEoi, autoEoiN, rotAuto, rotAutoN;
  logic              nested, nestedN, needIcw4, needIcw4N;
  initStep_t         step, stepN;

  logic [IDX_W:0]    reqPrio, curPrio, isrPrio;
  logic [LINES-1:0]  isrMask;
  logic [IDX_W-1:0]  isrTop, winIdx;
  logic              winValid;

  always_comb begin
    isrMask  = isr;
    if (IS_MASTER && nested) isrMask[CASCADE_LINE] = 1'b0;
    reqPrio  = pickPrio(irr & ~imr, prioAdd);
    curPrio  = pickPrio(isrMask, prioAdd);
    isrPrio  = pickPrio(isr, prioAdd);
    isrTop   = isrPrio[IDX_W-1:0] + prioAdd;
    winValid = !reqPrio[IDX_W] && (reqPrio < curPrio);
    winIdx   = reqPrio[IDX_W-1:0] + prioAdd;
  end

  always_comb begin
    irrN = irr; imrN = imr; isrN = isr; elcrN = elcr;
    prioAddN = prioAdd; baseN = base; readIsrN = readIsr;
    autoEoiN = autoEoi; rotAutoN = rotAuto; nestedN = nested;
    needIcw4N = needIcw4; stepN = step;

    if (strobe.ackEn) begin
      if (!elcr[strobe.ackIdx]) irrN[strobe.ackIdx] = 1'b0;
      if (autoEoi) begin
        if (rotAuto) prioAddN = strobe.ackIdx + 1'b1;
      end else begin
        isrN[strobe.ackIdx] = 1'b1;
      end
    end

    if (strobe.trigWr) elcrN = wrData & TRIG_MASK;

    if (strobe.cmdWr) begin
      if (wrData[4]) begin
        needIcw4N = wrData[0];
        imrN      = '0;
        prioAddN  = '0;
        readIsrN  = 1'b0;
        if (!wrData[0]) begin
          nestedN  = 1'b0;
          autoEoiN = 1'b0;
        end
        stepN = STEP_BASE;
      end else if (wrData[3]) begin
        if (wrData[1]) readIsrN = wrData[0];
      end else begin
        case (wrData[7:5])
          3'd0, 3'd4: rotAutoN = wrData[7];
          3'd1, 3'd5: if (!isrPrio[IDX_W]) begin
            isrN[isrTop] = 1'b0;
            if (wrData[7]) prioAddN = isrTop + 1'b1;
          end
          3'd3: isrN[wrData[IDX_W-1:0]] = 1'b0;
          3'd6: prioAddN = wrData[IDX_W-1:0] + 1'b1;
          3'd7: begin
            isrN[wrData[IDX_W-1:0]] = 1'b0;
            prioAddN = wrData[IDX_W-1:0] + 1'b1;
          end
          default: ;
        endcase
      end
    end

    if (strobe.dataWr) begin
      case (step)
        STEP_IDLE: imrN = wrData;
        STEP_BASE: begin
          baseN = wrData[BYTE_W-1:IDX_W];
          stepN = STEP_CASC;
        end
        STEP_CASC: stepN = needIcw4 ? STEP_MODE : STEP_IDLE;
        default: begin
          nestedN  = wrData[4];
          autoEoiN = wrData[1];
          stepN    = STEP_IDLE;
        end
      endcase
    end

    // line inputs last: a new edge beats a same-cycle acknowledge
    irrN = (irrN & ~elcr) | (reqLines & ~lastReq & ~elcr) | (reqLines & elcr) | injLines;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr <= '0; imr <= '0; isr <= '0; elcr <= '0; lastReq <= '0;
      prioAdd <= '0; base <= '0; readIsr <= 1'b0; autoEoi <= 1'b0;
      rotAuto <= 1'b0; nested <= 1'b0; needIcw4 <= 1'b0; step <= STEP_IDLE;
    end else begin
      irr <= irrN; imr <= imrN; isr <= isrN; elcr <= elcrN; lastReq <= reqLines;
      prioAdd <= prioAddN; base <= baseN; readIsr <= readIsrN; autoEoi <= autoEoiN;
      rotAuto <= rotAutoN; nested <= nestedN; needIcw4 <= needIcw4N; step <= stepN;
    end
  end

  assign intOut = winValid;
  always_comb begin
    view.winValid = winValid;
    view.winIdx   = winIdx;
    view.base     = base;
    view.regView  = readIsr ? isr : irr;
    view.imr      = imr;
    view.elcr     = elcr;
    view.irr      = irr;
  end

  // R7: a non-auto-EOI acknowledge leaves its input in service
  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackEn && !autoEoi && !strobe.cmdWr) |=> isr[$past(strobe.ackIdx)]);

  // R5: level-mode requests mirror the line one cycle later
  p_level_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((irr & $past(elcr) & ~$past(injLines)) ==
              ($past(reqLines) & $past(elcr) & ~$past(injLines))));
endmodule

// File: rtl/pic_pair_datapath.sv
module pic_pair_datapath
  import pic_pair_pkg::*;
#(
  parameter logic [LINES-1:0] MASTER_TRIG_MASK = 8'hF8,
  parameter logic [LINES-1:0] SLAVE_TRIG_MASK  = 8'hDE,
  parameter int               CASCADE_LINE     = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [SLICES*LINES-1:0]   irqLines,
  input  logic [BYTE_W-1:0]         wrData,
  input  sliceStrobe_t [SLICES-1:0] strobes,
  output sliceView_t   [SLICES-1:0] views,
  output logic                      cpuInt
);
  logic [SLICES-1:0] sliceInt;
  logic [LINES-1:0]  injMaster;

  // slave request enters master input as an edge; held off while the
  // master is being acknowledged so the in-flight request is not doubled
  always_comb begin
    injMaster = '0;
    injMaster[CASCADE_LINE] = sliceInt[1] && !strobes[0].ackEn;
  end

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    localparam bit               IS_M = (g == 0);
    localparam logic [LINES-1:0] TMSK = IS_M ? MASTER_TRIG_MASK : SLAVE_TRIG_MASK;
    pic_slice #(
      .IS_MASTER    (IS_M),
      .TRIG_MASK    (TMSK),
      .CASCADE_LINE (CASCADE_LINE)
    ) u_slice (
      .clk      (clk),
      .rstN     (rstN),
      .reqLines (irqLines[g*LINES +: LINES]),
      .injLines (IS_M ? injMaster : '0),
      .strobe   (strobes[g]),
      .wrData   (wrData),
      .view     (views[g]),
      .intOut   (sliceInt[g])
    );
  end

  assign cpuInt = sliceInt[0];

  // R6: an eligible slave request shows up at master input 2
  p_cascade_inject_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sliceInt[1] && !strobes[0].ackEn) |=> views[0].irr[CASCADE_LINE]);
endmodule

// File: rtl/pic_pair_ctrl.sv
module pic_pair_ctrl
  import pic_pair_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] M_CMD_ADDR   = 16'h0020,
  parameter logic [ADDR_W-1:0] S_CMD_ADDR   = 16'h00A0,
  parameter logic [ADDR_W-1:0] M_TRIG_ADDR  = 16'h04D0,
  parameter int                CASCADE_LINE = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         ioAddr,
  input  logic                      ioWrEn,
  input  logic                      ioRdEn,
  input  logic [2:0]                ioSize,
  input  logic                      intAck,
  input  sliceView_t   [SLICES-1:0] views,
  output sliceStrobe_t [SLICES-1:0] strobes,
  output logic [BYTE_W-1:0]         ioRdData,
  output logic [BYTE_W-1:0]         intVector
);
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(LINES - 1);

  portHit_t          hit;
  logic              sizeOk;
  logic [BYTE_W-1:0] rdNext, vecNext;

  assign sizeOk = (ioSize == 3'd1);

  always_comb begin
    if      (ioAddr == M_CMD_ADDR)        hit = HIT_MCMD;
    else if (ioAddr == M_CMD_ADDR + 1'b1) hit = HIT_MDATA;
    else if (ioAddr == S_CMD_ADDR)        hit = HIT_SCMD;
    else if (ioAddr == S_CMD_ADDR + 1'b1) hit = HIT_SDATA;
    else if (ioAddr == M_TRIG_ADDR)       hit = HIT_MTRIG;
    else if (ioAddr == M_TRIG_ADDR + 1'b1) hit = HIT_STRIG;
    else                                  hit = HIT_NONE;
  end

  always_comb begin
    strobes = '0;
    if (ioWrEn && sizeOk) begin
      strobes[0].cmdWr  = (hit == HIT_MCMD);
      strobes[0].dataWr = (hit == HIT_MDATA);
      strobes[0].trigWr = (hit == HIT_MTRIG);
      strobes[1].cmdWr  = (hit == HIT_SCMD);
      strobes[1].dataWr = (hit == HIT_SDATA);
      strobes[1].trigWr = (hit == HIT_STRIG);
    end
    vecNext = {views[0].base, SPUR_IDX};
    if (intAck && views[0].winValid) begin
      strobes[0].ackEn  = 1'b1;
      strobes[0].ackIdx = views[0].winIdx;
      if (views[0].winIdx == IDX_W'(CASCADE_LINE)) begin
        if (views[1].winValid) begin
          strobes[1].ackEn  = 1'b1;
          strobes[1].ackIdx = views[1].winIdx;
          vecNext = {views[1].base, views[1].winIdx};
        end else begin
          vecNext = {views[1].base, SPUR_IDX};
        end
      end else begin
        vecNext = {views[0].base, views[0].winIdx};
      end
    end
  end

  always_comb begin
    case (hit)
      HIT_MCMD:  rdNext = views[0].regView;
      HIT_MDATA: rdNext = views[0].imr;
      HIT_SCMD:  rdNext = views[1].regView;
      HIT_SDATA: rdNext = views[1].imr;
      HIT_MTRIG: rdNext = views[0].elcr;
      HIT_STRIG: rdNext = views[1].elcr;
      default:   rdNext = '0;
    endcase
    if (!sizeOk) rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioRdData  <= '0;
      intVector <= '0;
    end else begin
      if (ioRdEn) ioRdData  <= rdNext;
      if (intAck) intVector <= vecNext;
    end
  end

  // R2: reads outside the six claimed addresses return zero
  p_unclaimed_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdEn && ioAddr != M_CMD_ADDR && ioAddr != M_CMD_ADDR + 1'b1 &&
     ioAddr != S_CMD_ADDR && ioAddr != S_CMD_ADDR + 1'b1 &&
     ioAddr != M_TRIG_ADDR && ioAddr != M_TRIG_ADDR + 1'b1) |=> ioRdData == '0);

  // R3: reads of any size other than one byte return zero
  p_size_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdEn && ioSize != 3'd1) |=> ioRdData == '0);

  // R9: no master winner gives master base plus 7
  p_master_spurious_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !views[0].winValid) |=> intVector == {$past(views[0].base), SPUR_IDX});
endmodule

// File: rtl/pic_pair.sv
module pic_pair
  import pic_pair_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SLICES*LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]       ioAddr,
  input  logic [BYTE_W-1:0]       ioWrData,
  input  logic                    ioWrEn,
  input  logic                    ioRdEn,
  input  logic [2:0]              ioSize,
  input  logic                    intAck,
  output logic                    cpuInt,
  output logic [BYTE_W-1:0]       ioRdData,
  output logic [BYTE_W-1:0]       intVector
);
  sliceStrobe_t [SLICES-1:0] strobes;
  sliceView_t   [SLICES-1:0] views;

  pic_pair_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ioAddr    (ioAddr),
    .ioWrEn    (ioWrEn),
    .ioRdEn    (ioRdEn),
    .ioSize    (ioSize),
    .intAck    (intAck),
    .views     (views),
    .strobes   (strobes),
    .ioRdData  (ioRdData),
    .intVector (intVector)
  );

  pic_pair_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .irqLines (irqLines),
    .wrData   (ioWrData),
    .strobes  (strobes),
    .views    (views),
    .cpuInt   (cpuInt)
  );
endmodule

// File: tb/pic_pair_bench.sv
module pic_pair_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irq = '0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        ioWrEn = 1'b0, ioRdEn = 1'b0, intAck = 1'b0;
  logic [2:0]  ioSize = 3'd1;
  logic        cpuInt;
  logic [7:0]  ioRdData, intVector;
  int          nChk = 0, nBad = 0;

  always #2.5 clk = ~clk;

  pic_pair u_pic_pair (
    .clk(clk), .rstN(rstN), .irqLines(irq), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioSize(ioSize), .intAck(intAck),
    .cpuInt(cpuInt), .ioRdData(ioRdData), .intVector(intVector)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [15:0] a, input logic [7:0] d, input logic [2:0] sz = 3'd1);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioSize = sz; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0; ioSize = 3'd1;
  endtask

  task automatic busRd(input logic [15:0] a, output logic [7:0] v, input logic [2:0] sz = 3'd1);
    @(negedge clk);
    ioAddr = a; ioSize = sz; ioRdEn = 1'b1;
    @(negedge clk);
    ioRdEn = 1'b0; ioSize = 3'd1;
    v = ioRdData;
  endtask

  task automatic doAck(output logic [7:0] v);
    @(negedge clk);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
    v = intVector;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 reset cpuInt", cpuInt, 0);
    chk("R7 reset vector", intVector, 8'h00);
    busRd(16'h0021, v); chk("R1 reset mask", v, 8'h00);

    // R12: init both slices, master base 0x20, slave base 0x28
    busWr(16'h0020, 8'h11); busWr(16'h0021, 8'h20); busWr(16'h0021, 8'h04); busWr(16'h0021, 8'h01);
    busWr(16'h00A0, 8'h11); busWr(16'h00A1, 8'h28); busWr(16'h00A1, 8'h02); busWr(16'h00A1, 8'h01);

    // R2: unclaimed addresses
    busWr(16'h0022, 8'hFF); busWr(16'h04D2, 8'hFF);
    busRd(16'h0021, v); chk("R2 mask untouched", v, 8'h00);
    busRd(16'h04D0, v); chk("R2 trigger untouched", v, 8'h00);
    busRd(16'h0022, v); chk("R2 unclaimed read", v, 8'h00);
    // R3: wrong access sizes
    busWr(16'h0021, 8'hFF, 3'd2);
    busRd(16'h0021, v); chk("R3 wide write ignored", v, 8'h00);
    busWr(16'h00A1, 8'h40);
    busRd(16'h00A1, v, 3'd4); chk("R3 wide read zero", v, 8'h00);
    busRd(16'h00A1, v); chk("R1 slave mask read", v, 8'h40);
    busWr(16'h00A1, 8'h00);

    // sweep of every line
    for (int n = 0; n < 16; n++) begin
      logic [7:0] exp;
      irq[n] = 1'b1;
      settle();
      chk($sformatf("R6 cpuInt line %0d", n), cpuInt, 1);
      doAck(v);
      if (n == 2) begin
        exp = 8'h2F;
        chk("R8 slave spurious", v, exp);
      end else if (n < 8) begin
        exp = 8'h20 + 8'(n);
        chk($sformatf("R4 R7 line %0d", n), v, exp);
      end else begin
        exp = 8'h28 + 8'(n - 8);
        chk($sformatf("R4 R8 line %0d", n), v, exp);
      end
      irq[n] = 1'b0;
      if (n >= 8) busWr(16'h00A0, 8'h20);
      busWr(16'h0020, 8'h20);
      settle();
      chk($sformatf("R10 EOI line %0d", n), cpuInt, 0);
    end

    // R11 mask, R9 master spurious
    busWr(16'h0021, 8'h10);
    irq[4] = 1'b1; settle();
    chk("R11 masked quiet", cpuInt, 0);
    doAck(v); chk("R9 master spurious", v, 8'h27);
    busRd(16'h0021, v); chk("R1 R11 mask read", v, 8'h10);
    busWr(16'h0021, 8'h00); settle();
    chk("R11 unmask delivers", cpuInt, 1);
    doAck(v); chk("R11 vector", v, 8'h24);
    irq[4] = 1'b0; busWr(16'h0020, 8'h20); settle();

    // R10 priority and in-service blocking
    irq[3] = 1'b1; irq[5] = 1'b1; settle();
    doAck(v); chk("R10 higher first", v, 8'h23);
    settle(); chk("R10 blocked by isr", cpuInt, 0);
    busWr(16'h0020, 8'h20); settle();
    chk("R10 released", cpuInt, 1);
    doAck(v); chk("R10 second", v, 8'h25);
    irq[3] = 1'b0; irq[5] = 1'b0; busWr(16'h0020, 8'h20); settle();

    // R1 readback select, R7 isr/irr effect
    irq[1] = 1'b1; settle();
    doAck(v); chk("R7 line 1", v, 8'h21);
    busWr(16'h0020, 8'h0B);
    busRd(16'h0020, v); chk("R1 R7 isr view", v, 8'h02);
    busRd(16'h00A0, v); chk("R1 slave irr view", v, 8'h00);
    busWr(16'h0020, 8'h0A);
    busRd(16'h0020, v); chk("R1 R7 irr cleared", v, 8'h00);
    irq[1] = 1'b0; busWr(16'h0020, 8'h20); settle();

    // R5 trigger mode
    busWr(16'h04D0, 8'hFF); busRd(16'h04D0, v); chk("R5 master writable", v, 8'hF8);
    busWr(16'h04D1, 8'hFF); busRd(16'h04D1, v); chk("R5 slave writable", v, 8'hDE);
    busWr(16'h04D1, 8'h00); busWr(16'h04D0, 8'h08);
    irq[3] = 1'b1; settle();
    busRd(16'h0020, v); chk("R5 level set", v, 8'h08);
    irq[3] = 1'b0; settle();
    busRd(16'h0020, v); chk("R5 level drops", v, 8'h00);
    irq[3] = 1'b1; settle();
    doAck(v); chk("R5 level vector", v, 8'h23);
    busRd(16'h0020, v); chk("R5 ack keeps level", v, 8'h08);
    irq[3] = 1'b0; busWr(16'h0020, 8'h20); busWr(16'h04D0, 8'h00); settle();
    chk("R5 quiet after", cpuInt, 0);

    // R12 re-init with auto-EOI, R13 priority set
    busWr(16'h0021, 8'h55);
    busWr(16'h0020, 8'h11); busWr(16'h0021, 8'h43); busWr(16'h0021, 8'h04); busWr(16'h0021, 8'h03);
    busRd(16'h0021, v); chk("R12 mask cleared", v, 8'h00);
    busWr(16'h0020, 8'hC4);
    irq[1] = 1'b1; irq[6] = 1'b1; settle();
    doAck(v); chk("R12 R13 rotated winner", v, 8'h46);
    busWr(16'h0020, 8'h0B);
    busRd(16'h0020, v); chk("R12 auto EOI isr", v, 8'h00);
    settle();
    doAck(v); chk("R13 next winner", v, 8'h41);
    irq[1] = 1'b0; irq[6] = 1'b0; settle();
    chk("R6 idle end", cpuInt, 0);

    summary();
    $finish;
  end
endmodule